// File: doc/BRIEF.md
# ECC Error Logging and Threshold Unit

This block sits beside a memory's error-correcting datapath and keeps the records that software reads when errors happen. The datapath reports each correctable (single-bit) error and each uncorrectable (multi-bit) error as a one-cycle event pulse with the failing address. Correctable errors are counted against a programmable threshold. When the count reaches the threshold, a sticky flag is raised, the counter restarts from zero and part of the failing address is kept. The first uncorrectable error is captured in full and held until software clears its flag.

Software reaches the unit over a plain register bus with separate read and write strobes, a byte offset and a data word. Logging can be turned off as a whole without touching the datapath. An interrupt output follows the correctable-error flag under its own enable bit.

Two two-state machines carry the flags. The correctable side has states SE_CLEAR and SE_PENDING. It moves SE_CLEAR to SE_PENDING on a threshold hit, and SE_PENDING to SE_CLEAR on a write-one-to-clear with no hit in the same cycle. Its counter runs in one of three modes: CNT_OFF when logging is disabled, CNT_TRACK when the threshold is nonzero, and CNT_FREE when the threshold is zero. The uncorrectable side has states UE_EMPTY and UE_HELD. It moves UE_EMPTY to UE_HELD on a logged event, and UE_HELD to UE_EMPTY on a clear with no event in the same cycle. UE_HELD re-captures only when an event coincides with a clear.

Top module: `ecc_err_logger`

## Requirements
- R1: After reset every register reads zero, `irq` is low and `bus_rdata` is zero.
- R2: With logging enabled and a nonzero threshold, each correctable event that does not reach the threshold adds one to the count at offset 0x08. Uncorrectable events never change the count.
- R3: A correctable event for which count+1 is at least the threshold sets status bit 0, returns the count to zero and captures the address. A threshold of 1 therefore fires on every event.
- R4: The register at offset 0x10 holds the captured address bits 17 down to 3 in those same bit positions. All other bits read zero.
- R5: With a threshold of zero, correctable events never set status bit 0. The count rises to its maximum (2^CW-1) and stays there.
- R6: An uncorrectable event sets status bit 1 and captures the full address at offset 0x14. While bit 1 is set, later events leave that address unchanged, unless the event arrives in the same cycle as a write that clears bit 1; that event is captured.
- R7: While control bit 0 (logging enable) is 0, event pulses change no count, flag or address.
- R8: Status bits at offset 0x0C are write-one-to-clear. Writing 0 to a bit leaves it unchanged. A set and a clear in the same cycle leave the bit set.
- R9: `irq` is high exactly when status bit 0 and control bit 1 (interrupt enable) are both 1.
- R10: Offset 0x00 reads back control bits [1:0] and offset 0x04 reads back the threshold in bits [CW-1:0]. Writes to 0x08, 0x10 and 0x14 have no effect. Reads of any other offset return zero. Read data appears in the cycle after `bus_rd` and is zero after a cycle without a read. Events and writes take effect at the clock edge, and a register read issued in that same cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| se_evt | input | 1 | Correctable-error event pulse |
| se_addr | input | EAW | Address of the correctable error |
| ue_evt | input | 1 | Uncorrectable-error event pulse |
| ue_addr | input | EAW | Address of the uncorrectable error |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq | output | 1 | Correctable-error interrupt |

## Verification
The bench builds the unit with a 4-bit counter, 32-bit addresses and the default slice of bits 17 to 3. With a 4-bit counter, saturation at 15 is reached in a short directed run, and the random threshold values from 0 to 15 cover the zero, one and above-count cases often. The random phase also mixes threshold and control rewrites with events in the same cycle. This exercises the old-value rules and the set-over-clear priority on both flags.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
    localparam int OFF_CTRL  = 0;
    localparam int OFF_THR   = 4;
    localparam int OFF_CNT   = 8;
    localparam int OFF_STAT  = 12;
    localparam int OFF_SEADR = 16;
    localparam int OFF_UEADR = 20;

    localparam int CTRL_LOG = 0;
    localparam int CTRL_IEN = 1;
    localparam int STAT_SE  = 0;
    localparam int STAT_UE  = 1;

    typedef enum logic {SE_CLEAR, SE_PENDING} se_state_e;
    typedef enum logic {UE_EMPTY, UE_HELD} ue_state_e;
    typedef enum logic [1:0] {CNT_OFF, CNT_TRACK, CNT_FREE} cnt_mode_e;
endpackage

// File: rtl/ecclog_se_tracker.sv
module ecclog_se_tracker
    import ecclog_pkg::*;
#(
    parameter int CW  = 16,
    parameter int EAW = 32,
    parameter int SLO = 3,
    parameter int SHI = 17,
    localparam int SW = SHI - SLO + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           log_en,
    input  logic           evt,
    input  logic [EAW-1:0] evt_addr,
    input  logic [CW-1:0]  thr,
    input  logic           clr,
    output logic [CW-1:0]  cnt_o,
    output logic           flag_o,
    output logic [SW-1:0]  slice_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    se_state_e     state_q, state_d;
    cnt_mode_e     mode;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [SW-1:0] slice_q, slice_d;
    logic [CW:0]   cnt_inc;
    logic          hit;
    logic          unused_addr;

    assign unused_addr = ^evt_addr;
    assign cnt_inc = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};

    always_comb begin
        if (!log_en)        mode = CNT_OFF;
        else if (thr == '0) mode = CNT_FREE;
        else                mode = CNT_TRACK;
    end

    assign hit = evt && (mode == CNT_TRACK) && (cnt_inc >= {1'b0, thr});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SE_CLEAR;
            cnt_q   <= '0;
            slice_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slice_q <= slice_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SE_CLEAR:   state_d = hit ? SE_PENDING : SE_CLEAR;
            SE_PENDING: state_d = (clr && !hit) ? SE_CLEAR : SE_PENDING;
            default:    state_d = SE_CLEAR;
        endcase
    end

    always_comb begin
        cnt_d   = cnt_q;
        slice_d = slice_q;
        unique case (mode)
            CNT_OFF: cnt_d = cnt_q;
            CNT_TRACK: begin
                if (hit) begin
                    cnt_d   = '0;
                    slice_d = evt_addr[SHI:SLO];
                end else if (evt) begin
                    cnt_d = cnt_inc[CW-1:0];
                end
            end
            CNT_FREE: begin
                if (evt && cnt_q != CMAX) cnt_d = cnt_inc[CW-1:0];
            end
            default: cnt_d = cnt_q;
        endcase
    end

    assign cnt_o   = cnt_q;
    assign flag_o  = (state_q == SE_PENDING);
    assign slice_o = slice_q;

    // R3: reaching the threshold raises the flag and restarts the count
    a_r3_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && evt && thr != '0 && ({1'b0, cnt_o} + 1'b1) >= {1'b0, thr})
        |=> (flag_o && cnt_o == '0));

    // R2: below the threshold the count steps by one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && evt && thr != '0 && ({1'b0, cnt_o} + 1'b1) < {1'b0, thr})
        |=> (cnt_o == CW'($past(cnt_o) + 1'b1)));

    // R5: zero threshold saturates without flagging
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && evt && thr == '0 && cnt_o == CMAX && !clr)
        |=> (cnt_o == CMAX && flag_o == $past(flag_o)));

    // R7: logging disabled freezes count and captured address
    a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !log_en |=> ($stable(cnt_o) && $stable(slice_o)));
endmodule

// File: rtl/ecclog_ue_tracker.sv
module ecclog_ue_tracker
    import ecclog_pkg::*;
#(
    parameter int EAW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           log_en,
    input  logic           evt,
    input  logic [EAW-1:0] evt_addr,
    input  logic           clr,
    output logic           flag_o,
    output logic [EAW-1:0] addr_o
);
    ue_state_e      state_q, state_d;
    logic [EAW-1:0] addr_q, addr_d;
    logic           cap;

    assign cap = log_en && evt && (state_q == UE_EMPTY || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UE_EMPTY;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        addr_d  = cap ? evt_addr : addr_q;
        unique case (state_q)
            UE_EMPTY: state_d = cap ? UE_HELD : UE_EMPTY;
            UE_HELD:  state_d = (clr && !cap) ? UE_EMPTY : UE_HELD;
            default:  state_d = UE_EMPTY;
        endcase
    end

    assign flag_o = (state_q == UE_HELD);
    assign addr_o = addr_q;

    // R6: a held address survives until the flag is cleared
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr) |=> (flag_o && $stable(addr_o)));

    // R7: no capture while logging is disabled
    a_r7_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!log_en && !flag_o) |=> !flag_o);
endmodule

// File: rtl/ecclog_regbank.sv
module ecclog_regbank
    import ecclog_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int EAW = 32,
    parameter int SLO = 3,
    parameter int SHI = 17,
    localparam int SW = SHI - SLO + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic [CW-1:0]  cnt,
    input  logic           se_flag,
    input  logic [SW-1:0]  se_slice,
    input  logic           ue_flag,
    input  logic [EAW-1:0] ue_addr,
    output logic           log_en,
    output logic           int_en,
    output logic [CW-1:0]  thr,
    output logic           se_clr,
    output logic           ue_clr
);
    logic [1:0]    ctrl_q;
    logic [CW-1:0] thr_q;
    logic [DW-1:0] rd_mux, rdata_q;
    logic          wr_ctrl, wr_thr, wr_stat;
    logic          unused_wd;

    assign unused_wd = ^bus_wdata;
    assign wr_ctrl = bus_wr && (bus_addr == AW'(OFF_CTRL));
    assign wr_thr  = bus_wr && (bus_addr == AW'(OFF_THR));
    assign wr_stat = bus_wr && (bus_addr == AW'(OFF_STAT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            thr_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata[1:0];
            if (wr_thr)  thr_q  <= bus_wdata[CW-1:0];
            rdata_q <= bus_rd ? rd_mux : '0;
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            AW'(OFF_CTRL):  rd_mux[1:0] = ctrl_q;
            AW'(OFF_THR):   rd_mux[CW-1:0] = thr_q;
            AW'(OFF_CNT):   rd_mux[CW-1:0] = cnt;
            AW'(OFF_STAT): begin
                rd_mux[STAT_SE] = se_flag;
                rd_mux[STAT_UE] = ue_flag;
            end
            AW'(OFF_SEADR): rd_mux[SHI:SLO] = se_slice;
            AW'(OFF_UEADR): rd_mux[EAW-1:0] = ue_addr;
            default:        rd_mux = '0;
        endcase
    end

    assign bus_rdata = rdata_q;
    assign log_en    = ctrl_q[CTRL_LOG];
    assign int_en    = ctrl_q[CTRL_IEN];
    assign thr       = thr_q;
    assign se_clr    = wr_stat && bus_wdata[STAT_SE];
    assign ue_clr    = wr_stat && bus_wdata[STAT_UE];

    // R10: idle cycles return zero read data
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // R10: offsets past the last register read zero
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > AW'(OFF_UEADR)) |=> (bus_rdata == '0));
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
    import ecclog_pkg::*;
#(
    parameter int AW  = 8,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int EAW = 32,
    parameter int SLO = 3,
    parameter int SHI = 17
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           se_evt,
    input  logic [EAW-1:0] se_addr,
    input  logic           ue_evt,
    input  logic [EAW-1:0] ue_addr,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic           irq
);
    localparam int SW = SHI - SLO + 1;

    logic           log_en, int_en, se_clr, ue_clr, se_flag, ue_flag;
    logic [CW-1:0]  thr, cnt;
    logic [SW-1:0]  se_slice;
    logic [EAW-1:0] ue_cap;

    ecclog_regbank #(.AW(AW), .DW(DW), .CW(CW), .EAW(EAW), .SLO(SLO), .SHI(SHI)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt(cnt), .se_flag(se_flag), .se_slice(se_slice),
        .ue_flag(ue_flag), .ue_addr(ue_cap),
        .log_en(log_en), .int_en(int_en), .thr(thr),
        .se_clr(se_clr), .ue_clr(ue_clr)
    );

    ecclog_se_tracker #(.CW(CW), .EAW(EAW), .SLO(SLO), .SHI(SHI)) u_se (
        .clk(clk), .rst_n(rst_n), .log_en(log_en),
        .evt(se_evt), .evt_addr(se_addr), .thr(thr), .clr(se_clr),
        .cnt_o(cnt), .flag_o(se_flag), .slice_o(se_slice)
    );

    ecclog_ue_tracker #(.EAW(EAW)) u_ue (
        .clk(clk), .rst_n(rst_n), .log_en(log_en),
        .evt(ue_evt), .evt_addr(ue_addr), .clr(ue_clr),
        .flag_o(ue_flag), .addr_o(ue_cap)
    );

    assign irq = se_flag & int_en;

    // R9: the interrupt stays low without its enable
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);

    // R2: uncorrectable events alone leave the count alone
    a_r2_ue_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (ue_evt && !se_evt) |=> $stable(cnt));
endmodule

// File: tb/sim_ecc_err_logger.sv
module sim_ecc_err_logger;
    localparam int CLK_NS = 10;
    localparam int CW  = 4;
    localparam int EAW = 32;
    localparam int DW  = 32;
    localparam int AW  = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic se_evt = 0, ue_evt = 0, bus_wr = 0, bus_rd = 0;
    logic [EAW-1:0] se_addr = '0, ue_addr = '0;
    logic [AW-1:0]  bus_addr = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic           irq;

    ecc_err_logger #(.AW(AW), .DW(DW), .CW(CW), .EAW(EAW)) u0 (
        .clk(clk), .rst_n(rst_n), .se_evt(se_evt), .se_addr(se_addr),
        .ue_evt(ue_evt), .ue_addr(ue_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    logic [1:0]    m_ctrl = '0;
    logic [CW-1:0] m_thr = '0, m_cnt = '0;
    logic          m_sef = 0, m_uef = 0;
    logic [31:0]   m_sea = '0, m_uea = '0;
    int n_chk = 0, n_err = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] slice_of(input logic [31:0] a);
        return a & 32'h0003_FFF8;
    endfunction

    task automatic model_step(input logic se, input logic [31:0] sa, input logic ue,
                              input logic [31:0] ua, input logic wr,
                              input logic [7:0] wa, input logic [31:0] wd);
        logic se_set = 0, ue_cap = 0;
        logic clr_se = wr && wa == 8'h0C && wd[0];
        logic clr_ue = wr && wa == 8'h0C && wd[1];
        if (m_ctrl[0] && se) begin
            if (m_thr != 0) begin
                if (int'(m_cnt) + 1 >= int'(m_thr)) begin
                    se_set = 1; m_cnt = '0; m_sea = slice_of(sa);
                end else m_cnt = m_cnt + 1'b1;
            end else if (m_cnt != {CW{1'b1}}) m_cnt = m_cnt + 1'b1;
        end
        if (m_ctrl[0] && ue && (!m_uef || clr_ue)) begin
            ue_cap = 1; m_uea = ua;
        end
        if (wr && wa == 8'h00) m_ctrl = wd[1:0];
        if (wr && wa == 8'h04) m_thr = wd[CW-1:0];
        m_sef = se_set ? 1'b1 : (clr_se ? 1'b0 : m_sef);
        m_uef = ue_cap ? 1'b1 : (clr_ue ? 1'b0 : m_uef);
    endtask

    task automatic cyc(input logic se, input logic [31:0] sa, input logic ue,
                       input logic [31:0] ua, input logic wr,
                       input logic [7:0] wa, input logic [31:0] wd);
        se_evt = se; se_addr = sa; ue_evt = ue; ue_addr = ua;
        bus_wr = wr; bus_addr = wa; bus_wdata = wd;
        @(posedge clk);
        model_step(se, sa, ue, ua, wr, wa, wd);
        @(negedge clk);
        se_evt = 0; ue_evt = 0; bus_wr = 0;
        check("R9 irq", {31'b0, irq}, {31'b0, m_sef & m_ctrl[1]});
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        cyc(0, 0, 0, 0, 1, a, d);
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_rd = 1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 0;
        check(req, bus_rdata, exp);
    endtask

    task automatic chk_all();
        rd_chk(8'h00, {30'b0, m_ctrl}, "R10 ctrl");
        rd_chk(8'h04, {28'b0, m_thr}, "R10 thr");
        rd_chk(8'h08, {28'b0, m_cnt}, "R2 count");
        rd_chk(8'h0C, {30'b0, m_uef, m_sef}, "R8 status");
        rd_chk(8'h10, m_sea, "R4 se addr");
        rd_chk(8'h14, m_uea, "R6 ue addr");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1;
        @(negedge clk);
        for (int a = 0; a < 24; a += 4) rd_chk(8'(a), 32'h0, "R1 reset value");

        // R3: threshold 1, every event fires; R4 slice
        wr_reg(8'h00, 32'h1);
        wr_reg(8'h04, 32'h1);
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0);
        rd_chk(8'h0C, 32'h1, "R3 flag on threshold 1");
        rd_chk(8'h10, 32'h0003_FFF8, "R4 slice only");
        rd_chk(8'h08, 32'h0, "R3 count restart");
        check("R9 irq gated off", {31'b0, irq}, 32'h0);
        wr_reg(8'h00, 32'h3);
        check("R9 irq on", {31'b0, irq}, 32'h1);
        wr_reg(8'h0C, 32'h0);
        rd_chk(8'h0C, 32'h1, "R8 write zero keeps");
        wr_reg(8'h0C, 32'h1);
        rd_chk(8'h0C, 32'h0, "R8 w1c clears");

        // R2/R3: threshold 3
        wr_reg(8'h04, 32'h3);
        cyc(1, 32'h0000_1238, 0, 0, 0, 0, 0);
        cyc(1, 32'h0000_2230, 0, 0, 0, 0, 0);
        rd_chk(8'h08, 32'h2, "R2 count two");
        rd_chk(8'h0C, 32'h0, "R3 no flag below");
        cyc(1, 32'hABCD_5678, 0, 0, 0, 0, 0);
        rd_chk(8'h0C, 32'h1, "R3 flag at 3");
        rd_chk(8'h10, 32'h0001_5678, "R4 captured slice");
        wr_reg(8'h0C, 32'h1);

        // R6: uncorrectable capture and hold
        cyc(0, 0, 1, 32'hDEAD_BEEF, 0, 0, 0);
        cyc(0, 0, 1, 32'h1111_2222, 0, 0, 0);
        rd_chk(8'h14, 32'hDEAD_BEEF, "R6 first held");
        rd_chk(8'h08, 32'h0, "R2 ue no count");
        cyc(0, 0, 1, 32'h3333_4444, 1, 8'h0C, 32'h2);
        rd_chk(8'h14, 32'h3333_4444, "R6 capture with clear");
        rd_chk(8'h0C, 32'h2, "R8 set wins ue");

        // R7: logging off
        wr_reg(8'h0C, 32'h3);
        wr_reg(8'h00, 32'h2);
        cyc(1, 32'h5555_5555, 1, 32'h6666_6666, 0, 0, 0);
        cyc(1, 32'h5555_5555, 0, 0, 0, 0, 0);
        cyc(1, 32'h5555_5555, 0, 0, 0, 0, 0);
        rd_chk(8'h0C, 32'h0, "R7 no flags");
        rd_chk(8'h08, 32'h0, "R7 no count");
        rd_chk(8'h14, 32'h3333_4444, "R7 ue addr kept");

        // R5: zero threshold saturates
        wr_reg(8'h00, 32'h1);
        wr_reg(8'h04, 32'h0);
        for (int i = 0; i < 20; i++) cyc(1, 32'h0000_0100, 0, 0, 0, 0, 0);
        rd_chk(8'h08, 32'hF, "R5 saturated");
        rd_chk(8'h0C, 32'h0, "R5 no flag");

        // R10: read-only and unmapped
        wr_reg(8'h08, 32'h0);
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_chk(8'h08, 32'hF, "R10 count write ignored");
        rd_chk(8'h10, 32'h0001_5678, "R10 se addr write ignored");
        rd_chk(8'h18, 32'h0, "R10 unmapped 0x18");
        rd_chk(8'h40, 32'h0, "R10 unmapped 0x40");
        @(negedge clk);
        check("R10 idle rdata zero", bus_rdata, 32'h0);

        // R8: set beats clear in the same cycle
        wr_reg(8'h04, 32'h1);
        cyc(1, 32'h0000_0808, 0, 0, 1, 8'h0C, 32'h1);
        rd_chk(8'h0C, 32'h1, "R8 set wins se");
        chk_all();

        // random phase
        void'($urandom(32'd20240));
        for (int i = 0; i < 4000; i++) begin
            logic se = ($urandom % 3) == 0;
            logic ue = ($urandom % 8) == 0;
            logic wr = ($urandom % 10) == 0;
            logic [7:0] wa = 8'(($urandom % 7) * 4);
            logic [31:0] wd = $urandom;
            if (wa == 8'h00 && ($urandom % 4) != 0) wd[0] = 1'b1;
            cyc(se, $urandom, ue, $urandom, wr, wa, wd);
            if ((i % 16) == 15) chk_all();
        end
        chk_all();

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule